// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home side of a directory-based coherence scheme for a distributed-memory multiprocessor. It keeps the memory storage for a set of blocks. For every block it also keeps a directory entry: a state and a presence vector with one bit per node. Nodes send it three kinds of request: a read miss, a write miss, or a write-back of a dirty block. For each request the controller updates the entry. It then sends out what the protocol needs: invalidations to readers, a fetch to the owner (which may also drop the owner's copy), and finally a data reply to the requester.

Requests are handled one at a time. While a request is in flight, or while the controller waits for an owner's data, the request port is held not-ready. Requesters block until their reply arrives, and messages are taken to be delivered in order. Data that comes back from an owner is written into memory and forwarded to the requester in the same step.

Top module: `dirc_home`

## Requirements
- R1: After reset every block is uncached and holds data 0, `reqReady` is 1 and `msgValid` is 0.
- R2: A read miss (`reqKind` 0) to an uncached or shared block produces one data reply (`msgKind` 0) to the requester. The reply carries the block's memory value. The block becomes shared, and the requester is added to the nodes already recorded.
- R3: A write miss (`reqKind` 1) to an uncached block produces one data reply with the memory value. The block becomes exclusive, owned by the requester.
- R4: A write miss to a shared block first sends an invalidate (`msgKind` 1) to every recorded reader except the requester, in ascending node order. It then sends the data reply. The block becomes exclusive to the requester.
- R5: A read miss to an exclusive block sends a fetch (`msgKind` 2) to the owner and waits for `fillValid`. The fill data is written to memory and forwarded in the reply. The block becomes shared by both the owner and the requester.
- R6: A write miss to an exclusive block sends a fetch-and-invalidate (`msgKind` 3) to the owner and forwards the fill data in the reply. The requester becomes the sole owner.
- R7: A write-back (`reqKind` 2) from the owner of an exclusive block stores `reqData` in memory and makes the block uncached. No message is sent.
- R8: A write-back from a node that does not own the block, or to a block that is not exclusive, sends no message and leaves both memory and the directory unchanged.
- R9: `reqReady` is 0 from the cycle after a read or write miss is accepted until its data reply has been accepted. This includes the whole wait for fill data.
- R10: An outgoing message whose `msgReady` is 0 stays valid with unchanged kind, destination, address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can accept a request |
| reqKind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| reqNode | input | ID_W | Requesting node |
| reqAddr | input | AW | Block index |
| reqData | input | DATA_W | Write-back data |
| fillValid | input | 1 | Owner data present |
| fillData | input | DATA_W | Owner data |
| msgValid | output | 1 | Outgoing message present |
| msgReady | input | 1 | Network accepts the message |
| msgKind | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msgDest | output | ID_W | Destination node |
| msgAddr | output | AW | Block index |
| msgData | output | DATA_W | Reply data |

## Verification
A corrupted presence vector shows up at the next write miss to that block. Invalidates then go to the wrong set of nodes, or the controller fetches from a node that is not the owner. A wrong block state shows up on the very next request to the block, as a missing or unexpected fetch. Stale memory shows up as a wrong value in a later reply that needs no fetch. The directed sequences chain requests on the same block so that each transition is observed through the message stream of the request that follows it.

// File: rtl/dirc_pkg.sv
package dirc_pkg;
  typedef enum logic [1:0] {ST_UNC = 2'd0, ST_SHR = 2'd1, ST_EXC = 2'd2} blkState_t;
  typedef enum logic [1:0] {MSG_DATA = 2'd0, MSG_INV = 2'd1, MSG_FETCH = 2'd2, MSG_FETCHX = 2'd3} msgKind_t;
  localparam logic [1:0] REQ_RD = 2'd0;
  localparam logic [1:0] REQ_WR = 2'd1;
  localparam logic [1:0] REQ_WB = 2'd2;
  typedef struct packed {
    logic     take;      // latch request, update directory for a miss
    logic     wbCommit;  // owner write-back: store data, clear entry
    logic     invPop;    // current invalidate accepted
    logic     fillTake;  // owner data arrived
    msgKind_t msgSel;    // which message the outputs carry
  } ctlStrobe_t;
endpackage

// File: rtl/dirc_datapath.sv
module dirc_datapath
  import dirc_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DATA_W = 16,
  localparam int ID_W = $clog2(NODES),
  localparam int AW   = $clog2(BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [1:0]        reqKind,
  input  logic [ID_W-1:0]   reqNode,
  input  logic [AW-1:0]     reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] fillData,
  output blkState_t         lkState,
  output logic              lkOwnerHit,
  output logic              lkInvAny,
  output logic              invMore,
  output logic [ID_W-1:0]   msgDest,
  output logic [AW-1:0]     msgAddr,
  output logic [DATA_W-1:0] msgData
);
  blkState_t         stArr [BLOCKS];
  logic [NODES-1:0]  shArr [BLOCKS];
  logic [DATA_W-1:0] memArr[BLOCKS];

  logic [AW-1:0]     curAddr;
  logic [ID_W-1:0]   curNode;
  logic [ID_W-1:0]   curOwner;
  logic [NODES-1:0]  pendMask;
  logic [DATA_W-1:0] replyData;

  logic [NODES-1:0]  reqBit;
  logic [NODES-1:0]  lkSharers;
  logic [NODES-1:0]  lowOh;
  logic [ID_W-1:0]   lowIdx;
  logic [ID_W-1:0]   lkOwner;

  assign reqBit     = NODES'(1) << reqNode;
  assign lkSharers  = shArr[reqAddr];
  assign lkState    = stArr[reqAddr];
  assign lkOwnerHit = lkSharers[reqNode];
  assign lkInvAny   = |(lkSharers & ~reqBit);
  assign lowOh      = pendMask & (~pendMask + NODES'(1));
  assign invMore    = |(pendMask & ~lowOh);

  always_comb begin
    lkOwner = '0;
    for (int i = NODES - 1; i >= 0; i--)
      if (lkSharers[i]) lkOwner = ID_W'(i);
  end

  always_comb begin
    lowIdx = '0;
    for (int i = NODES - 1; i >= 0; i--)
      if (pendMask[i]) lowIdx = ID_W'(i);
  end

  always_comb begin
    unique case (ctl.msgSel)
      MSG_DATA: msgDest = curNode;
      MSG_INV:  msgDest = lowIdx;
      default:  msgDest = curOwner;
    endcase
  end
  assign msgAddr = curAddr;
  assign msgData = replyData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < BLOCKS; b++) begin
        stArr[b]  <= ST_UNC;
        shArr[b]  <= '0;
        memArr[b] <= '0;
      end
      curAddr   <= '0;
      curNode   <= '0;
      curOwner  <= '0;
      pendMask  <= '0;
      replyData <= '0;
    end else begin
      if (ctl.take) begin
        curAddr   <= reqAddr;
        curNode   <= reqNode;
        curOwner  <= lkOwner;
        pendMask  <= lkSharers & ~reqBit;
        replyData <= memArr[reqAddr];
        if (reqKind == REQ_RD) begin
          stArr[reqAddr] <= ST_SHR;
          shArr[reqAddr] <= ((lkState == ST_UNC) ? '0 : lkSharers) | reqBit;
        end else begin
          stArr[reqAddr] <= ST_EXC;
          shArr[reqAddr] <= reqBit;
        end
      end
      if (ctl.wbCommit) begin
        stArr[reqAddr]  <= ST_UNC;
        shArr[reqAddr]  <= '0;
        memArr[reqAddr] <= reqData;
      end
      if (ctl.invPop) pendMask <= pendMask & ~lowOh;
      if (ctl.fillTake) begin
        memArr[curAddr] <= fillData;
        replyData       <= fillData;
      end
    end
  end
endmodule

// File: rtl/dirc_control.sv
module dirc_control
  import dirc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  blkState_t  lkState,
  input  logic       lkOwnerHit,
  input  logic       lkInvAny,
  input  logic       invMore,
  input  logic       msgReady,
  input  logic       fillValid,
  output logic       reqReady,
  output logic       msgValid,
  output ctlStrobe_t ctl
);
  typedef enum logic [2:0] {C_IDLE, C_INVAL, C_FETCH, C_WAITF, C_REPLY} ctlState_t;
  ctlState_t state, stateNxt;
  logic fetchX, fetchXNxt;
  logic accept;

  assign reqReady = (state == C_IDLE);
  assign accept   = reqValid && reqReady;
  assign msgValid = (state == C_INVAL) || (state == C_FETCH) || (state == C_REPLY);

  always_comb begin
    ctl.take     = accept && (reqKind == REQ_RD || reqKind == REQ_WR);
    ctl.wbCommit = accept && (reqKind == REQ_WB) && (lkState == ST_EXC) && lkOwnerHit;
    ctl.invPop   = (state == C_INVAL) && msgReady;
    ctl.fillTake = (state == C_WAITF) && fillValid;
    unique case (state)
      C_INVAL: ctl.msgSel = MSG_INV;
      C_FETCH: ctl.msgSel = fetchX ? MSG_FETCHX : MSG_FETCH;
      default: ctl.msgSel = MSG_DATA;
    endcase
  end

  always_comb begin
    stateNxt  = state;
    fetchXNxt = fetchX;
    unique case (state)
      C_IDLE: if (accept) begin
        if (reqKind == REQ_RD) begin
          if (lkState == ST_EXC) begin stateNxt = C_FETCH; fetchXNxt = 1'b0; end
          else stateNxt = C_REPLY;
        end else if (reqKind == REQ_WR) begin
          if (lkState == ST_EXC) begin stateNxt = C_FETCH; fetchXNxt = 1'b1; end
          else if (lkState == ST_SHR && lkInvAny) stateNxt = C_INVAL;
          else stateNxt = C_REPLY;
        end
      end
      C_INVAL: if (msgReady && !invMore) stateNxt = C_REPLY;
      C_FETCH: if (msgReady) stateNxt = C_WAITF;
      C_WAITF: if (fillValid) stateNxt = C_REPLY;
      C_REPLY: if (msgReady) stateNxt = C_IDLE;
      default: stateNxt = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= C_IDLE;
      fetchX <= 1'b0;
    end else begin
      state  <= stateNxt;
      fetchX <= fetchXNxt;
    end
  end
endmodule

// File: rtl/dirc_home.sv
module dirc_home
  import dirc_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DATA_W = 16,
  localparam int ID_W = $clog2(NODES),
  localparam int AW   = $clog2(BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic [ID_W-1:0]   reqNode,
  input  logic [AW-1:0]     reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              fillValid,
  input  logic [DATA_W-1:0] fillData,
  output logic              msgValid,
  input  logic              msgReady,
  output logic [1:0]        msgKind,
  output logic [ID_W-1:0]   msgDest,
  output logic [AW-1:0]     msgAddr,
  output logic [DATA_W-1:0] msgData
);
  ctlStrobe_t ctl;
  blkState_t  lkState;
  logic       lkOwnerHit, lkInvAny, invMore;

  dirc_control u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .lkState(lkState), .lkOwnerHit(lkOwnerHit), .lkInvAny(lkInvAny),
    .invMore(invMore), .msgReady(msgReady), .fillValid(fillValid),
    .reqReady(reqReady), .msgValid(msgValid), .ctl(ctl)
  );

  dirc_datapath #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqKind(reqKind), .reqNode(reqNode),
    .reqAddr(reqAddr), .reqData(reqData), .fillData(fillData),
    .lkState(lkState), .lkOwnerHit(lkOwnerHit), .lkInvAny(lkInvAny),
    .invMore(invMore), .msgDest(msgDest), .msgAddr(msgAddr), .msgData(msgData)
  );

  assign msgKind = ctl.msgSel;
endmodule

// File: rtl/dirc_home_chk.sv
module dirc_home_chk #(
  parameter int ID_W   = 2,
  parameter int AW     = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ID_W-1:0]   reqNode,
  input logic              msgValid,
  input logic              msgReady,
  input logic [1:0]        msgKind,
  input logic [ID_W-1:0]   msgDest,
  input logic [AW-1:0]     msgAddr,
  input logic [DATA_W-1:0] msgData
);
  logic [ID_W-1:0] lastNode;
  always_ff @(posedge clk) begin
    if (!rstN) lastNode <= '0;
    else if (reqValid && reqReady) lastNode <= reqNode;
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgKind) && $stable(msgDest)
      && $stable(msgAddr) && $stable(msgData));

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> !reqReady);

  assert_waitfill_R5: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgReady && msgKind == 2'd2 |=> !reqReady && !msgValid);

  assert_noselfinv_R4: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgKind == 2'd1 |-> msgDest != lastNode);

  assert_replydest_R2: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgKind == 2'd0 |-> msgDest == lastNode);
endmodule

bind dirc_home dirc_home_chk #(.ID_W(ID_W), .AW(AW), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqNode(reqNode), .msgValid(msgValid), .msgReady(msgReady),
  .msgKind(msgKind), .msgDest(msgDest), .msgAddr(msgAddr), .msgData(msgData)
);

// File: tb/sim_dirc_home.sv
module sim_dirc_home;
  localparam int NODES = 4, BLOCKS = 8, DATA_W = 16;
  localparam int ID_W = 2, AW = 3;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, fillValid = 0, msgReady = 0;
  logic [1:0] reqKind = 0;
  logic [ID_W-1:0] reqNode = 0;
  logic [AW-1:0] reqAddr = 0;
  logic [DATA_W-1:0] reqData = 0, fillData = 0;
  logic reqReady, msgValid;
  logic [1:0] msgKind;
  logic [ID_W-1:0] msgDest;
  logic [AW-1:0] msgAddr;
  logic [DATA_W-1:0] msgData;
  int nChk = 0, nFail = 0;

  always #4 clk = ~clk;

  dirc_home #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqNode(reqNode), .reqAddr(reqAddr), .reqData(reqData),
    .fillValid(fillValid), .fillData(fillData), .msgValid(msgValid),
    .msgReady(msgReady), .msgKind(msgKind), .msgDest(msgDest),
    .msgAddr(msgAddr), .msgData(msgData)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input int node, input int addr, input logic [DATA_W-1:0] d);
    @(negedge clk);
    chk(reqReady == 1'b1, "R9 ready before request", 32'(reqReady), 1);
    reqValid = 1; reqKind = k; reqNode = ID_W'(node); reqAddr = AW'(addr); reqData = d;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic expectMsg(input logic [1:0] k, input int dest, input int addr,
                           input logic [DATA_W-1:0] d, input string tag, input int stall);
    int n = 0;
    while (!msgValid && n < 20) begin @(negedge clk); n++; end
    chk(msgValid == 1'b1, {tag, " msg valid"}, 32'(msgValid), 1);
    chk(msgKind == k, {tag, " kind"}, 32'(msgKind), 32'(k));
    chk(msgDest == ID_W'(dest), {tag, " dest"}, 32'(msgDest), 32'(dest));
    chk(msgAddr == AW'(addr), {tag, " addr"}, 32'(msgAddr), 32'(addr));
    if (k == 2'd0) chk(msgData == d, {tag, " data"}, 32'(msgData), 32'(d));
    chk(reqReady == 1'b0, "R9 busy while message pending", 32'(reqReady), 0);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(msgValid && msgKind == k && msgDest == ID_W'(dest) && msgData == d,
          "R10 message held while stalled", 32'(msgData), 32'(d));
    end
    msgReady = 1;
    @(negedge clk);
    msgReady = 0;
  endtask

  task automatic giveFill(input logic [DATA_W-1:0] d, input string tag);
    @(negedge clk);
    chk(!msgValid && !reqReady, {tag, " R9 waiting for fill"}, 32'({msgValid, reqReady}), 0);
    fillValid = 1; fillData = d;
    @(negedge clk);
    fillValid = 0;
  endtask

  task automatic expectQuiet(input string tag);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!msgValid, {tag, " no message"}, 32'(msgValid), 0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready after reset", 32'(reqReady), 1);
    chk(msgValid == 1'b0, "R1 no message after reset", 32'(msgValid), 0);
    send(2'd0, 0, 3, 0);
    expectMsg(2'd0, 0, 3, 16'h0, "R1 R2 read uncached", 0);
  endtask

  task automatic t_shared_then_write;
    send(2'd0, 1, 3, 0);
    expectMsg(2'd0, 1, 3, 16'h0, "R2 read shared", 0);
    send(2'd1, 2, 3, 0);
    expectMsg(2'd1, 0, 3, 0, "R4 inval node0", 0);
    expectMsg(2'd1, 1, 3, 0, "R4 inval node1", 0);
    expectMsg(2'd0, 2, 3, 16'h0, "R4 reply", 0);
  endtask

  task automatic t_read_exclusive;
    send(2'd0, 3, 3, 0);
    expectMsg(2'd2, 2, 3, 0, "R5 fetch owner", 0);
    giveFill(16'hBEEF, "R5");
    expectMsg(2'd0, 3, 3, 16'hBEEF, "R5 forwarded", 0);
    send(2'd1, 0, 3, 0);
    expectMsg(2'd1, 2, 3, 0, "R5 owner kept as sharer", 0);
    expectMsg(2'd1, 3, 3, 0, "R5 requester sharer", 0);
    expectMsg(2'd0, 0, 3, 16'hBEEF, "R5 memory updated", 0);
  endtask

  task automatic t_write_exclusive_and_wb;
    send(2'd1, 1, 3, 0);
    expectMsg(2'd3, 0, 3, 0, "R6 fetch-inval owner", 0);
    giveFill(16'h1234, "R6");
    expectMsg(2'd0, 1, 3, 16'h1234, "R6 forwarded", 0);
    send(2'd2, 2, 3, 16'hAAAA);
    expectQuiet("R8 non-owner writeback");
    send(2'd2, 1, 3, 16'h5678);
    expectQuiet("R7 owner writeback");
    send(2'd0, 2, 3, 0);
    expectMsg(2'd0, 2, 3, 16'h5678, "R7 uncached with new data", 0);
    send(2'd2, 3, 3, 16'h9999);
    expectQuiet("R8 writeback to shared");
    send(2'd1, 3, 3, 0);
    expectMsg(2'd1, 2, 3, 0, "R8 directory unchanged", 0);
    expectMsg(2'd0, 3, 3, 16'h5678, "R8 memory unchanged", 0);
  endtask

  task automatic t_uncached_write;
    send(2'd1, 0, 5, 0);
    expectMsg(2'd0, 0, 5, 16'h0, "R3 write uncached", 0);
    send(2'd0, 1, 5, 0);
    expectMsg(2'd2, 0, 5, 0, "R3 owner recorded", 0);
    giveFill(16'h0077, "R3");
    expectMsg(2'd0, 1, 5, 16'h0077, "R3 fill reply", 0);
  endtask

  task automatic t_self_sharer_stall;
    send(2'd1, 1, 5, 0);
    expectMsg(2'd1, 0, 5, 0, "R4 only other sharer", 0);
    expectMsg(2'd0, 1, 5, 16'h0077, "R4 R10 stalled reply", 3);
    @(negedge clk);
    chk(reqReady == 1'b1, "R9 ready after reply", 32'(reqReady), 1);
  endtask

  initial begin
    #(8 * 100000);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_shared_then_write();
    t_read_exclusive();
    t_write_exclusive_and_wb();
    t_uncached_write();
    t_self_sharer_stall();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule